// File: doc/BRIEF.md
# Flash Byte-Program Suspend/Resume Controller

This block is the command interpreter of a parallel flash device that can pause a byte program, serve reads from the rest of the array, and then carry on. Bus write cycles deliver 8-bit command codes and the program address and data. The controller keeps a status byte and drives a ready/busy line. A read-mode selector decides whether the read port returns array contents or the status byte. A down-counter stands in for the internal program algorithm and has fixed program and suspend latencies. The array is a small behavioural byte memory that is set to all ones at reset. Programming can only clear bits, so a programmed byte becomes the old value ANDed with the data.

The program-voltage level and the reset-pin level appear as two digital qualifier inputs. Both are captured when a program starts and must not change until the program finishes. Suspend takes effect only after a fixed number of cycles. While the program is suspended, only three commands are honoured, and the byte under program is hidden from array reads.

Top module: `flash_pgm_susp_ctrl`

## Requirements
- R1: After reset the array holds 0xFF everywhere, ready is 1, array-read mode is selected (rd_status = 0) and the status byte is 0x80. Status byte fields are: bit 7 ready, bit 4 program error, bit 3 program-voltage low, bit 2 program suspended, and all other bits 0.
- R2: Code 0x40 followed by a second write (address, data) starts a byte program. From the next cycle ready is 0, status mode is selected and status reads 0x00. Ready returns to 1 after PGM_LAT+1 clock edges counted from the data write. The addressed byte then holds the old value AND the data.
- R3: Code 0xB0 written while a program is running with time left selects status mode at once. Ready stays 0 for SUSP_LAT more edges and rises on the edge after those. From then on, status reads with bits 7 and 2 both set (0x84 when no error flag is set).
- R4: While suspended, only 0xFF, 0x70 and 0xD0 have an effect. Any other code, including 0x40, 0x50 and 0xB0, leaves the read mode, the status and the suspended state unchanged.
- R5: While suspended in array-read mode, every address other than the suspended one returns its array contents, and the suspended address returns 0xFF.
- R6: Code 0xD0 while suspended clears status bits 7 and 2, drives ready to 0 and selects status mode on the next edge.
- R7: A suspended program keeps its remaining cycle count. If the suspend is taken on edge j after the data write (1 <= j <= PGM_LAT), ready rises exactly PGM_LAT+1-j edges after the resume write. The byte is written once.
- R8: Code 0xB0 when no program is running changes nothing: ready stays 1, the read mode is kept, and status reads 0x80. A 0xB0 that arrives on the same edge as program completion is also ignored.
- R9: Starting a program with vpp_ok = 0 writes nothing, leaves ready at 1 and sets status bits 4 and 3 (0x98). If vpp_ok or rp_hi differs from its value at program start while the program is running, pending suspend or suspended, the program is abandoned on the next edge: ready goes to 1, status bit 4 is set, and the byte is left unchanged.
- R10: Code 0x50 while idle clears status bits 4 and 3.
- R11: While idle, 0x70 selects status mode (rd_status = 1) and 0xFF selects array-read mode (rd_status = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | ADDR_W | Write address (used for the program data write) |
| wr_data | input | 8 | Command code or program data |
| rd_addr | input | ADDR_W | Read address |
| vpp_ok | input | 1 | Program-voltage present qualifier |
| rp_hi | input | 1 | Reset-pin level qualifier |
| rd_data | output | 8 | Array data or status byte, per the read mode |
| ready | output | 1 | 1 = ready, 0 = busy |
| rd_status | output | 1 | 1 = reads return status, 0 = reads return array |

## Verification
A wrong internal state is visible at the ports within one cycle. If the state is wrong, ready holds the wrong level or the status byte loses or gains bit 2 on the next edge. A lost or corrupted remaining count changes the number of edges between resume and ready, and the bench counts that number exactly. A bad address latch, or a write at the wrong moment, shows on the next array read: the suspended byte does not read 0xFF, or the byte after completion does not equal the AND of its old value and the data.

// File: rtl/fps_pkg.sv
// Shared types and constants for the program suspend/resume controller.
// Assumes 8-bit command codes and an 8-bit status byte.
package fps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PROG,
        ST_SPEND,
        ST_SUSP
    } fps_state_t;

    localparam logic [7:0] CMD_SUSPEND   = 8'hB0;
    localparam logic [7:0] CMD_RESUME    = 8'hD0;
    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_PGM_SETUP = 8'h40;
    localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

    localparam int SB_READY   = 7;
    localparam int SB_PGM_ERR = 4;
    localparam int SB_VPP_LOW = 3;
    localparam int SB_SUSP    = 2;
endpackage

// File: rtl/fps_timer.sv
// Two load-and-count-down channels. Channel 0 models the program algorithm
// and channel 1 the suspend latency. Assumes a load takes priority over a
// decrement, and that a counter at zero holds there.
module fps_timer #(
    parameter int PGM_LAT  = 8,
    parameter int SUSP_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] load,
    input  logic [1:0] run,
    output logic [1:0] zero
);
    localparam int MAXL = (PGM_LAT > SUSP_LAT) ? PGM_LAT : SUSP_LAT;
    localparam int CW   = $clog2(MAXL + 1);

    genvar g;
    for (g = 0; g < 2; g++) begin : g_ch
        localparam int LIM = (g == 0) ? PGM_LAT : SUSP_LAT;
        logic [CW-1:0] cnt;

        // Load the channel's latency, or count down while running.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (load[g])
                cnt <= CW'(LIM);
            else if (run[g] && cnt != '0)
                cnt <= cnt - 1'b1;
        end

        assign zero[g] = (cnt == '0);
    end
endmodule

// File: rtl/fps_array.sv
// Behavioural byte array: set to 0xFF at reset, and a write can only clear
// bits (old AND new). Assumes a small depth; the read is combinational.
module fps_array #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Erase everything at reset and AND the data into the addressed byte on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/flash_pgm_susp_ctrl.sv
// Command controller for byte program with suspend/resume. It decodes bus
// write cycles, runs the program timer, latches the program target, and
// picks status or array data for the read port.
// Assumes one command per cycle, qualifiers synchronous to clk, and that
// error flags stay set until a clear command is written while idle.
module flash_pgm_susp_ctrl
    import fps_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PGM_LAT  = 8,
    parameter int SUSP_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              vpp_ok,
    input  logic              rp_hi,
    output logic [7:0]        rd_data,
    output logic              ready,
    output logic              rd_status
);
    fps_state_t        state;
    logic              stat_mode;
    logic              err_pgm, err_vpp;
    logic [ADDR_W-1:0] pgm_addr;
    logic [7:0]        pgm_data;
    logic [1:0]        qual_ref;
    logic [1:0]        t_load, t_run, t_zero;
    logic              pgm_zero, susp_zero;
    logic              qual_ok, active, abort, complete, susp_acc, start_ok;
    logic [7:0]        status, arr_q;

    assign qual_ok   = ({vpp_ok, rp_hi} == qual_ref);
    assign active    = (state == ST_PROG) || (state == ST_SPEND) || (state == ST_SUSP);
    assign abort     = active && !qual_ok;
    assign pgm_zero  = t_zero[0];
    assign susp_zero = t_zero[1];
    assign complete  = (state == ST_PROG) && pgm_zero && qual_ok;
    assign susp_acc  = (state == ST_PROG) && qual_ok && !pgm_zero
                       && wr_en && (wr_data == CMD_SUSPEND);
    assign start_ok  = (state == ST_SETUP) && wr_en && vpp_ok;

    assign t_load = {susp_acc, start_ok};
    assign t_run  = {(state == ST_SPEND) && qual_ok, (state == ST_PROG) && qual_ok};

    fps_timer #(.PGM_LAT(PGM_LAT), .SUSP_LAT(SUSP_LAT)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (t_load),
        .run  (t_run),
        .zero (t_zero)
    );

    fps_array #(.ADDR_W(ADDR_W)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (complete),
        .waddr(pgm_addr),
        .wdata(pgm_data),
        .raddr(rd_addr),
        .rdata(arr_q)
    );

    // Command sequencer: mode selection, program start, suspend and resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            stat_mode <= 1'b0;
            err_pgm   <= 1'b0;
            err_vpp   <= 1'b0;
            pgm_addr  <= '0;
            pgm_data  <= '0;
            qual_ref  <= '0;
        end else if (abort) begin
            state   <= ST_IDLE;
            err_pgm <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: if (wr_en) begin
                    case (wr_data)
                        CMD_RD_ARRAY:  stat_mode <= 1'b0;
                        CMD_RD_STATUS: stat_mode <= 1'b1;
                        CMD_CLR_STAT: begin
                            err_pgm <= 1'b0;
                            err_vpp <= 1'b0;
                        end
                        CMD_PGM_SETUP: state <= ST_SETUP;
                        default: ;
                    endcase
                end
                ST_SETUP: if (wr_en) begin
                    stat_mode <= 1'b1;
                    if (vpp_ok) begin
                        state    <= ST_PROG;
                        pgm_addr <= wr_addr;
                        pgm_data <= wr_data;
                        qual_ref <= {vpp_ok, rp_hi};
                    end else begin
                        state   <= ST_IDLE;
                        err_pgm <= 1'b1;
                        err_vpp <= 1'b1;
                    end
                end
                ST_PROG: begin
                    if (pgm_zero) begin
                        state <= ST_IDLE;
                    end else if (susp_acc) begin
                        state     <= ST_SPEND;
                        stat_mode <= 1'b1;
                    end
                end
                ST_SPEND: if (susp_zero) state <= ST_SUSP;
                ST_SUSP: if (wr_en) begin
                    case (wr_data)
                        CMD_RD_ARRAY:  stat_mode <= 1'b0;
                        CMD_RD_STATUS: stat_mode <= 1'b1;
                        CMD_RESUME: begin
                            state     <= ST_PROG;
                            stat_mode <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Compose the status byte from the state and the sticky error flags.
    always_comb begin
        status             = 8'h00;
        status[SB_READY]   = ready;
        status[SB_PGM_ERR] = err_pgm;
        status[SB_VPP_LOW] = err_vpp;
        status[SB_SUSP]    = (state == ST_SUSP);
    end

    assign ready     = !((state == ST_PROG) || (state == ST_SPEND));
    assign rd_status = stat_mode;

    // Read-port mux; the byte under a suspended program reads as erased.
    always_comb begin
        if (stat_mode)
            rd_data = status;
        else if (state == ST_SUSP && rd_addr == pgm_addr)
            rd_data = 8'hFF;
        else
            rd_data = arr_q;
    end
endmodule

// File: rtl/fps_checker.sv
// Property checker for the suspend/resume controller, bound to the top.
// Assumes it sees the sequencer state and the timer zero flags.
module fps_checker
    import fps_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              ready,
    input logic              rd_status,
    input fps_state_t        state,
    input logic              pgm_zero,
    input logic              susp_zero,
    input logic              qual_ok,
    input logic [ADDR_W-1:0] pgm_addr
);
    AST_SUSP_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && wr_en && wr_data == CMD_SUSPEND && !pgm_zero && qual_ok)
        |=> (!ready && rd_status)); // R3

    AST_SUSP_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPEND && susp_zero && qual_ok)
        |=> (ready && rd_status && rd_data[7] && rd_data[2])); // R3

    AST_SUSP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && qual_ok && wr_en && wr_data != CMD_RD_ARRAY
         && wr_data != CMD_RD_STATUS && wr_data != CMD_RESUME)
        |=> (state == ST_SUSP && $stable(rd_status) && ready)); // R4

    AST_HIDE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && !rd_status && rd_addr == pgm_addr)
        |-> (rd_data == 8'hFF)); // R5

    AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && qual_ok && wr_en && wr_data == CMD_RESUME)
        |=> (!ready && rd_status && !rd_data[2] && !rd_data[7])); // R6

    AST_IDLE_SUSP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && wr_data == CMD_SUSPEND)
        |=> (ready && $stable(rd_status))); // R8

    AST_QUAL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PROG || state == ST_SPEND || state == ST_SUSP) && !qual_ok)
        |=> ready); // R9
endmodule

bind flash_pgm_susp_ctrl fps_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ready    (ready),
    .rd_status(rd_status),
    .state    (state),
    .pgm_zero (pgm_zero),
    .susp_zero(susp_zero),
    .qual_ok  (qual_ok),
    .pgm_addr (pgm_addr)
);

// File: tb/sim_flash_pgm_susp_ctrl.sv
// Self-checking bench: directed corners plus seeded random program/suspend runs.
module sim_flash_pgm_susp_ctrl;
    localparam int AW  = 4;
    localparam int PL  = 8;
    localparam int SL  = 3;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          vpp_ok = 1'b1;
    logic          rp_hi = 1'b1;
    logic [7:0]    rd_data;
    logic          ready;
    logic          rd_status;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [DEP];

    always #5 clk = ~clk;

    flash_pgm_susp_ctrl #(.ADDR_W(AW), .PGM_LAT(PL), .SUSP_LAT(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .vpp_ok(vpp_ok), .rp_hi(rp_hi),
        .rd_data(rd_data), .ready(ready), .rd_status(rd_status)
    );

    function automatic logic [7:0] exp_stat(input logic rdy, input logic perr,
                                            input logic vlow, input logic susp);
        return {rdy, 2'b00, perr, vlow, susp, 2'b00};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEP; i++) model[i] = 8'hFF;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk("R1 ready", {7'd0, ready}, 8'd1);
        chk("R1 mode", {7'd0, rd_status}, 8'd0);
        rd(4'd9, v); chk("R1 erased", v, 8'hFF);

        // R11: read-mode selection
        cmd(0, 8'h70);
        chk("R11 status mode", {7'd0, rd_status}, 8'd1);
        chk("R1 status byte", rd_data, exp_stat(1, 0, 0, 0));
        cmd(0, 8'hFF);
        chk("R11 array mode", {7'd0, rd_status}, 8'd0);

        // R8: suspend while idle does nothing
        cmd(0, 8'hB0);
        chk("R8 ready", {7'd0, ready}, 8'd1);
        chk("R8 mode kept", {7'd0, rd_status}, 8'd0);
        cmd(0, 8'h70);
        chk("R8 status", rd_data, exp_stat(1, 0, 0, 0));

        // R2: directed program timing and AND semantics
        cmd(0, 8'h40);
        cmd(4'd3, 8'h5A);
        chk("R2 busy", {7'd0, ready}, 8'd0);
        chk("R2 busy status", rd_data, exp_stat(0, 0, 0, 0));
        for (int k = 1; k <= PL; k++) begin
            tick();
            chk("R2 still busy", {7'd0, ready}, 8'd0);
        end
        tick();
        chk("R2 done", {7'd0, ready}, 8'd1);
        model[3] = model[3] & 8'h5A;
        cmd(0, 8'hFF);
        rd(4'd3, v); chk("R2 data", v, model[3]);

        // R8: suspend on the completion edge is ignored
        cmd(0, 8'h40);
        cmd(4'd5, 8'h3C);
        repeat (PL) tick();
        cmd(0, 8'hB0);
        chk("R8 completion wins", {7'd0, ready}, 8'd1);
        chk("R8 no suspend flag", rd_data, exp_stat(1, 0, 0, 0));
        model[5] = model[5] & 8'h3C;

        // R3..R7: seeded random program/suspend/resume runs
        for (int it = 0; it < 14; it++) begin
            logic [AW-1:0] a, oth;
            logic [7:0] d, bad;
            int j, rem, cnt;
            a   = AW'($urandom % DEP);
            d   = 8'($urandom);
            j   = 1 + int'($urandom % PL);
            oth = a + AW'(1 + ($urandom % (DEP - 1)));
            do bad = 8'($urandom); while (bad == 8'hFF || bad == 8'h70 || bad == 8'hD0);
            if (it == 0) bad = 8'h40;
            if (it == 1) bad = 8'h50;
            if (it == 2) bad = 8'hB0;

            cmd(0, 8'h40);
            cmd(a, d);
            repeat (j - 1) tick();
            cmd(0, 8'hB0);
            chk("R3 status mode at once", {7'd0, rd_status}, 8'd1);
            chk("R3 busy after suspend", {7'd0, ready}, 8'd0);
            for (int k = 0; k < SL; k++) begin
                tick();
                chk("R3 latency busy", {7'd0, ready}, 8'd0);
            end
            tick();
            chk("R3 ready when suspended", {7'd0, ready}, 8'd1);
            chk("R3 suspend status", rd_data, exp_stat(1, 0, 0, 1));

            cmd(a, bad);
            chk("R4 ignored in status mode", rd_data, exp_stat(1, 0, 0, 1));
            cmd(0, 8'hFF);
            chk("R4 read array valid", {7'd0, rd_status}, 8'd0);
            rd(oth, v); chk("R5 other address", v, model[oth]);
            rd(a, v);   chk("R5 suspended address", v, 8'hFF);
            cmd(a, bad);
            chk("R4 ignored in array mode", {7'd0, rd_status}, 8'd0);
            chk("R4 still suspended", {7'd0, ready}, 8'd1);
            cmd(0, 8'h70);
            chk("R4 read status valid", rd_data, exp_stat(1, 0, 0, 1));

            cmd(0, 8'hD0);
            chk("R6 resume busy", {7'd0, ready}, 8'd0);
            chk("R6 resume status", rd_data, exp_stat(0, 0, 0, 0));
            rem = PL + 1 - j;
            cnt = 0;
            while (!ready && cnt < 4 * PL) begin
                tick();
                cnt++;
            end
            chk("R7 remaining cycles", 8'(cnt), 8'(rem));
            model[a] = model[a] & d;
            cmd(0, 8'hFF);
            rd(a, v); chk("R7 written once", v, model[a]);
        end

        // R9: program start without program voltage
        vpp_ok = 1'b0;
        cmd(0, 8'h40);
        cmd(4'd2, 8'h00);
        chk("R9 ready", {7'd0, ready}, 8'd1);
        chk("R9 vpp status", rd_data, exp_stat(1, 1, 1, 0));
        vpp_ok = 1'b1;
        cmd(0, 8'h50);
        chk("R10 clear", rd_data, exp_stat(1, 0, 0, 0));
        cmd(0, 8'hFF);
        rd(4'd2, v); chk("R9 untouched", v, model[2]);

        // R9: reset-pin level change while suspended abandons the program
        cmd(0, 8'h40);
        cmd(4'd6, 8'h00);
        tick();
        cmd(0, 8'hB0);
        repeat (SL + 1) tick();
        chk("R9 suspended first", rd_data, exp_stat(1, 0, 0, 1));
        rp_hi = 1'b0;
        tick();
        chk("R9 abort from suspend", rd_data, exp_stat(1, 1, 0, 0));
        rp_hi = 1'b1;

        // R9: program-voltage drop during program abandons it
        cmd(0, 8'h50);
        cmd(0, 8'h40);
        cmd(4'd7, 8'h00);
        tick();
        vpp_ok = 1'b0;
        tick();
        chk("R9 abort ready", {7'd0, ready}, 8'd1);
        chk("R9 abort status", rd_data, exp_stat(1, 1, 0, 0));
        vpp_ok = 1'b1;
        cmd(0, 8'h50);
        chk("R10 clear after abort", rd_data, exp_stat(1, 0, 0, 0));
        cmd(0, 8'hFF);
        rd(4'd6, v); chk("R9 byte 6 unchanged", v, model[6]);
        rd(4'd7, v); chk("R9 byte 7 unchanged", v, model[7]);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule